// File: doc/BRIEF.md
# PC Card Access Cycle Sequencer

This block runs one read or write at a time on a 16-bit PC Card or CompactFlash device. The device has three spaces: common memory, attribute memory and I/O. The host side presents a request that gives the space, the direction, the address, the transfer size and the write data. The block then drives the card's chip enables, register select, address and data lines, and exactly one read or write strobe. Each access has a setup cycle, an access phase with the strobe low, and a hold cycle. A single-cycle completion pulse follows the hold cycle.

Each space takes its access-phase length, in clock cycles, from its own configuration input. When the wait control is enabled, the card can stretch the access phase by pulling its active-low wait line low while the strobe is active. After the wait line goes high again, the strobe stays low for exactly four more cycles. Before any card line moves, the block checks the size and address combination and refuses the request if it is illegal. The illegal combinations are a high-lane odd byte, an odd word address and an odd attribute address.

Top module: `pccard_seq`

## Requirements
- R1: An accepted legal request gives exactly one setup cycle. In that cycle the address, chip enables and register select are valid and all four strobes are high. The strobe then goes low on the next cycle.
- R2: With no wait stretching, the strobe stays low for max(L,1) cycles. L is the length input of the space being accessed: memory uses cfg_mem_len, attribute uses cfg_attr_len and I/O uses cfg_io_len.
- R3: req_space encodes memory as 0, attribute as 1 and I/O as 2. Memory and attribute accesses use card_oe_n for reads and card_we_n for writes. I/O accesses use card_iord_n for reads and card_iowr_n for writes. No other strobe moves.
- R4: card_reg_n is low throughout attribute and I/O accesses and high throughout memory accesses.
- R5: A low-lane byte access (req_size 0) drives card_ce1_n low and card_ce2_n high, with address bit 0 equal to req_addr[0].
- R6: A word access (req_size 1) drives both chip enables low with address bit 0 at 0. A word request with req_addr[0]=1 is refused.
- R7: A refused request drives rsp_error high for one cycle, the cycle after acceptance. For a refused request, no chip enable, no strobe and no completion pulse occur. Requests refused this way are a high-lane odd byte (req_size 2), req_size 3 and req_space 3.
- R8: An attribute request with req_addr[0]=1 is refused as in R7.
- R9: When cfg_wait_en is 0, card_wait_n has no effect on the access-phase length.
- R10: When cfg_wait_en is 1, the strobe stays low while card_wait_n is low during the access phase. After card_wait_n returns high, the strobe stays low for exactly 4 more cycles, or until the R2 length is reached if that is later.
- R11: After the access phase, there is exactly one hold cycle with all strobes high and the address held. The next cycle is idle with rsp_done high for one cycle.
- R12: A read captures card_din on the last cycle of the access phase and presents it on rsp_rdata from the hold cycle onward.
- R13: A write drives card_doe high from setup through hold. It drives req_wdata on card_dout for a word, or {8'h00, req_wdata[7:0]} for a byte. card_doe is low in idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_mem_len | input | WAIT_W | Access-phase length for common memory |
| cfg_attr_len | input | WAIT_W | Access-phase length for attribute memory |
| cfg_io_len | input | WAIT_W | Access-phase length for I/O space |
| cfg_wait_en | input | 1 | Lets card_wait_n stretch the access phase |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle; a request is taken this cycle |
| req_space | input | 2 | 0 memory, 1 attribute, 2 I/O, 3 refused |
| req_size | input | 2 | 0 low byte, 1 word, 2 high-lane odd byte (refused), 3 refused |
| req_write | input | 1 | 1 write, 0 read |
| req_addr | input | ADDR_W | Card address |
| req_wdata | input | 16 | Write data |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_error | output | 1 | One-cycle refusal pulse |
| rsp_rdata | output | 16 | Read data |
| card_ce1_n | output | 1 | Low-byte chip enable |
| card_ce2_n | output | 1 | High-byte chip enable |
| card_reg_n | output | 1 | Register/attribute select |
| card_oe_n | output | 1 | Memory read strobe |
| card_we_n | output | 1 | Memory write strobe |
| card_iord_n | output | 1 | I/O read strobe |
| card_iowr_n | output | 1 | I/O write strobe |
| card_wait_n | input | 1 | Card wait request, active low |
| card_addr | output | ADDR_W | Card address bus |
| card_dout | output | 16 | Data driven to the card |
| card_doe | output | 1 | Data output enable |
| card_din | input | 16 | Data from the card |

## Verification
The stimulus walks every legal combination of space, size and direction with a distinct phase length for each space. This separates a wrong length-input choice, a wrong strobe and a wrong chip-enable pattern. Each illegal encoding is sent on its own to show that refusal leaves the card lines quiet. The card model returns data that changes every strobe cycle, so the captured value shows exactly which cycle was sampled. The same wait pattern is run with the wait control on and off, and with wait releases before and after the programmed length. This separates the four-cycle tail from the base length and from an ignored wait line.

// File: rtl/pccard_pkg.sv
package pccard_pkg;

  typedef enum logic [1:0] {
    SP_MEM  = 2'd0,
    SP_ATT  = 2'd1,
    SP_IO   = 2'd2,
    SP_NONE = 2'd3
  } space_e;

  typedef enum logic [1:0] {
    SZ_LOW_BYTE  = 2'd0,
    SZ_WORD      = 2'd1,
    SZ_HIGH_BYTE = 2'd2,
    SZ_NONE      = 2'd3
  } size_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETUP  = 2'd1,
    ST_ACCESS = 2'd2,
    ST_HOLD   = 2'd3
  } state_e;

  // cycles the strobe stays low after the card releases its wait line
  localparam int unsigned TAIL_CYCLES = 4;

  typedef struct packed {
    logic ce1_n;
    logic ce2_n;
    logic reg_n;
    logic a0;
  } lane_t;

  // a request is legal when space and size are known, a word is even,
  // and an attribute access is even
  function automatic logic access_legal(space_e sp, size_e sz, logic a0);
    logic ok;
    ok = (sp != SP_NONE) && ((sz == SZ_LOW_BYTE) || (sz == SZ_WORD));
    if (sz == SZ_WORD && a0)
      ok = 1'b0;
    if (sp == SP_ATT && a0)
      ok = 1'b0;
    return ok;
  endfunction

  // chip enables, register select and address bit 0 for a legal request
  function automatic lane_t lane_pick(space_e sp, size_e sz, logic a0);
    lane_t l;
    l.reg_n = (sp == SP_MEM);
    if (sz == SZ_WORD) begin
      l.ce1_n = 1'b0;
      l.ce2_n = 1'b0;
      l.a0    = 1'b0;
    end else begin
      l.ce1_n = 1'b0;
      l.ce2_n = 1'b1;
      l.a0    = a0;
    end
    return l;
  endfunction

endpackage

// File: rtl/pccard_req_decode.sv
module pccard_req_decode
  import pccard_pkg::*;
(
  input  space_e space,
  input  size_e  size,
  input  logic   addr0,
  output logic   legal,
  output lane_t  lane
);

  always_comb begin
    legal = access_legal(space, size, addr0);
    lane  = lane_pick(space, size, addr0);
  end

endmodule

// File: rtl/pccard_phase_timer.sv
module pccard_phase_timer
  import pccard_pkg::*;
#(
  parameter int WAIT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm,
  input  logic              in_access,
  input  logic [WAIT_W-1:0] len_cfg,
  input  logic              wait_en,
  input  logic              wait_n,
  output logic              stall_ev,
  output logic              last
);

  localparam int TW = $clog2(TAIL_CYCLES + 1);

  // a programmed length of zero still gives one strobe cycle
  function automatic logic [WAIT_W-1:0] phase_len(logic [WAIT_W-1:0] cfg);
    return (cfg == '0) ? WAIT_W'(1) : cfg;
  endfunction

  logic [WAIT_W-1:0] cnt;
  logic [TW-1:0]     tail;
  logic [WAIT_W-1:0] len;
  logic              base_done;

  always_comb begin
    len       = phase_len(len_cfg);
    base_done = (cnt >= len);
    stall_ev  = in_access && wait_en && !wait_n;
    last      = in_access && base_done && !stall_ev && (tail <= TW'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      tail <= '0;
    end else if (arm) begin
      cnt  <= WAIT_W'(1);
      tail <= '0;
    end else if (in_access) begin
      if (!base_done)
        cnt <= cnt + WAIT_W'(1);
      if (stall_ev)
        tail <= TW'(TAIL_CYCLES);
      else if (tail != '0)
        tail <= tail - TW'(1);
    end
  end

  // R10
  tail_after_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_access && $past(stall_ev) && !stall_ev) |-> !last);

endmodule

// File: rtl/pccard_seq.sv
module pccard_seq
  import pccard_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int WAIT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WAIT_W-1:0] cfg_mem_len,
  input  logic [WAIT_W-1:0] cfg_attr_len,
  input  logic [WAIT_W-1:0] cfg_io_len,
  input  logic              cfg_wait_en,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_space,
  input  logic [1:0]        req_size,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [15:0]       req_wdata,
  output logic              rsp_done,
  output logic              rsp_error,
  output logic [15:0]       rsp_rdata,
  output logic              card_ce1_n,
  output logic              card_ce2_n,
  output logic              card_reg_n,
  output logic              card_oe_n,
  output logic              card_we_n,
  output logic              card_iord_n,
  output logic              card_iowr_n,
  input  logic              card_wait_n,
  output logic [ADDR_W-1:0] card_addr,
  output logic [15:0]       card_dout,
  output logic              card_doe,
  input  logic [15:0]       card_din
);

  localparam int DATA_W = 16;
  localparam int BYTE_W = DATA_W / 2;

  state_e            st;
  space_e            sp_q;
  size_e             sz_q;
  logic              wr_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  lane_t             lane_q;
  logic              done_q;
  logic              err_q;
  logic [DATA_W-1:0] rdata_q;

  // named events
  logic        legal_now;
  lane_t       lane_now;
  logic        accept;
  logic        go;
  logic        refuse;
  logic        bus_active;
  logic        strobe_on;
  logic        is_io;
  logic        stall_ev;
  logic        phase_last;
  logic [WAIT_W-1:0] len_sel;

  pccard_req_decode i_decode (
    .space (space_e'(req_space)),
    .size  (size_e'(req_size)),
    .addr0 (req_addr[0]),
    .legal (legal_now),
    .lane  (lane_now)
  );

  always_comb begin
    case (sp_q)
      SP_MEM:  len_sel = cfg_mem_len;
      SP_ATT:  len_sel = cfg_attr_len;
      default: len_sel = cfg_io_len;
    endcase
  end

  pccard_phase_timer #(.WAIT_W(WAIT_W)) i_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .arm       (st == ST_SETUP),
    .in_access (st == ST_ACCESS),
    .len_cfg   (len_sel),
    .wait_en   (cfg_wait_en),
    .wait_n    (card_wait_n),
    .stall_ev  (stall_ev),
    .last      (phase_last)
  );

  always_comb begin
    req_ready  = (st == ST_IDLE);
    accept     = req_ready && req_valid;
    go         = accept && legal_now;
    refuse     = accept && !legal_now;
    bus_active = (st != ST_IDLE);
    strobe_on  = (st == ST_ACCESS);
    is_io      = (sp_q == SP_IO);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      sp_q    <= SP_MEM;
      sz_q    <= SZ_LOW_BYTE;
      wr_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      lane_q  <= '{ce1_n: 1'b1, ce2_n: 1'b1, reg_n: 1'b1, a0: 1'b0};
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      done_q <= 1'b0;
      err_q  <= refuse;
      case (st)
        ST_IDLE: begin
          if (go) begin
            st      <= ST_SETUP;
            sp_q    <= space_e'(req_space);
            sz_q    <= size_e'(req_size);
            wr_q    <= req_write;
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
            lane_q  <= lane_now;
          end
        end
        ST_SETUP: st <= ST_ACCESS;
        ST_ACCESS: begin
          if (phase_last) begin
            st <= ST_HOLD;
            if (!wr_q)
              rdata_q <= card_din;
          end
        end
        default: begin
          st     <= ST_IDLE;
          done_q <= 1'b1;
        end
      endcase
    end
  end

  always_comb begin
    card_ce1_n  = bus_active ? lane_q.ce1_n : 1'b1;
    card_ce2_n  = bus_active ? lane_q.ce2_n : 1'b1;
    card_reg_n  = bus_active ? lane_q.reg_n : 1'b1;
    card_addr   = bus_active ? {addr_q[ADDR_W-1:1], lane_q.a0} : '0;
    card_oe_n   = !(strobe_on && !wr_q && !is_io);
    card_we_n   = !(strobe_on &&  wr_q && !is_io);
    card_iord_n = !(strobe_on && !wr_q &&  is_io);
    card_iowr_n = !(strobe_on &&  wr_q &&  is_io);
    card_doe    = bus_active && wr_q;
    if (!card_doe)
      card_dout = '0;
    else if (sz_q == SZ_WORD)
      card_dout = wdata_q;
    else
      card_dout = {{BYTE_W{1'b0}}, wdata_q[BYTE_W-1:0]};
    rsp_done    = done_q;
    rsp_error   = err_q;
    rsp_rdata   = rdata_q;
  end

  // R3
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({~card_oe_n, ~card_we_n, ~card_iord_n, ~card_iowr_n}));

  // R7
  refuse_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_error |-> (card_ce1_n && card_ce2_n && card_oe_n && card_we_n &&
                   card_iord_n && card_iowr_n && !rsp_done));

  // R1
  setup_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_SETUP) |=> (st == ST_ACCESS));

  // R11
  hold_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_HOLD) |-> ($stable(card_addr) && card_oe_n && card_we_n &&
                         card_iord_n && card_iowr_n));

  // R11
  done_after_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> $past(st == ST_HOLD));

  // R6
  word_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!card_ce1_n && !card_ce2_n) |-> (card_addr[0] == 1'b0));

  // R13
  idle_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !card_doe);

endmodule

// File: tb/test_pccard_seq.sv
`timescale 1ns/1ps
module test_pccard_seq;

  localparam int ADDR_W = 11;
  localparam int WAIT_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [WAIT_W-1:0] cfg_mem_len = '0, cfg_attr_len = '0, cfg_io_len = '0;
  logic cfg_wait_en = 1'b0;
  logic req_valid = 1'b0, req_ready, req_write = 1'b0;
  logic [1:0] req_space = '0, req_size = '0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic rsp_done, rsp_error;
  logic [15:0] rsp_rdata;
  logic ce1_n, ce2_n, reg_n, oe_n, we_n, iord_n, iowr_n, wait_n;
  logic [ADDR_W-1:0] card_addr;
  logic [15:0] card_dout, card_din;
  logic card_doe;

  int n_checks = 0;
  int n_err = 0;
  int cyc = 0;
  int low_cnt = 0;
  int wdly = 0;
  int wlen = 0;

  always #4 clk = ~clk;

  pccard_seq #(.ADDR_W(ADDR_W), .WAIT_W(WAIT_W)) i_pccard_seq (
    .clk(clk), .rst_n(rst_n),
    .cfg_mem_len(cfg_mem_len), .cfg_attr_len(cfg_attr_len), .cfg_io_len(cfg_io_len),
    .cfg_wait_en(cfg_wait_en),
    .req_valid(req_valid), .req_ready(req_ready), .req_space(req_space),
    .req_size(req_size), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata),
    .rsp_done(rsp_done), .rsp_error(rsp_error), .rsp_rdata(rsp_rdata),
    .card_ce1_n(ce1_n), .card_ce2_n(ce2_n), .card_reg_n(reg_n),
    .card_oe_n(oe_n), .card_we_n(we_n), .card_iord_n(iord_n), .card_iowr_n(iowr_n),
    .card_wait_n(wait_n), .card_addr(card_addr), .card_dout(card_dout),
    .card_doe(card_doe), .card_din(card_din)
  );

  // card model: data tracks the strobe cycle number, wait follows a window
  wire strobe_low = !(oe_n && we_n && iord_n && iowr_n);
  always @(posedge clk) low_cnt <= strobe_low ? low_cnt + 1 : 0;
  assign card_din = 16'hC000 + low_cnt[15:0];
  assign wait_n = !(wlen > 0 && strobe_low && low_cnt >= wdly && low_cnt < wdly + wlen);

  typedef struct {
    bit          is_err;
    int          len;
    logic [3:0]  strb;
    bit          ce1, ce2, regn, a0, wr;
    logic [15:0] rdata;
    logic [15:0] dout;
    string       tag;
  } exp_t;
  exp_t sb[$];

  task automatic check(bit ok, string req, string what, int act, int expv);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  // monitor
  int act_c = 0, low_c = 0, pre_c = 0, post_c = 0, doe_c = 0;
  logic [3:0] seen = '0;
  bit m_ce1, m_ce2, m_reg, m_a0;
  logic [15:0] m_dout;

  always @(negedge clk) begin
    if (rst_n) begin
      logic [3:0] s;
      s = {~oe_n, ~we_n, ~iord_n, ~iowr_n};
      if (!ce1_n || !ce2_n) begin
        act_c++;
        m_ce1 = ce1_n; m_ce2 = ce2_n; m_reg = reg_n; m_a0 = card_addr[0];
        if (s != 0) begin
          low_c++;
          seen = seen | s;
        end else if (low_c == 0) pre_c++;
        else post_c++;
        if (card_doe) begin
          doe_c++;
          m_dout = card_dout;
        end
      end else if (card_doe) begin
        check(0, "R13", "doe in idle", 1, 0);
      end
      if (rsp_done || rsp_error) begin
        if (sb.size() == 0) begin
          check(0, "R11", "unexpected response", 1, 0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          check(rsp_error == e.is_err, e.tag, "error flag", rsp_error, e.is_err);
          if (e.is_err) begin
            check(act_c == 0, e.tag, "card lines moved on refusal", act_c, 0);
          end else begin
            check(pre_c == 1, "R1", "setup cycles", pre_c, 1);
            check(low_c == e.len, e.tag, "strobe cycles", low_c, e.len);
            check(seen == e.strb, "R3", "strobe used", seen, e.strb);
            check(m_reg == e.regn, "R4", "reg select", m_reg, e.regn);
            check({m_ce1, m_ce2, m_a0} == {e.ce1, e.ce2, e.a0}, "R5/R6", "ce1,ce2,a0",
                  {m_ce1, m_ce2, m_a0}, {e.ce1, e.ce2, e.a0});
            check(post_c == 1, "R11", "hold cycles", post_c, 1);
            if (e.wr) begin
              check(doe_c == act_c, "R13", "doe cycles", doe_c, act_c);
              check(m_dout == e.dout, "R13", "write data", m_dout, e.dout);
            end else begin
              check(doe_c == 0, "R13", "doe on read", doe_c, 0);
              check(rsp_rdata == e.rdata, "R12", "read data", rsp_rdata, e.rdata);
            end
          end
        end
        act_c = 0; low_c = 0; pre_c = 0; post_c = 0; doe_c = 0; seen = '0;
      end
    end
  end

  // driver
  task automatic run_access(int sp, int sz, bit wr, int addr, logic [15:0] wd,
                            int cfg, string tag);
    exp_t e;
    int base;
    base = (cfg == 0) ? 1 : cfg;
    e.is_err = !(sp != 3 && sz < 2 && !(sz == 1 && addr[0]) && !(sp == 1 && addr[0]));
    e.len = base;
    if (cfg_wait_en && wlen > 0 && wdly < base)
      e.len = (wdly + wlen + 4 > base) ? wdly + wlen + 4 : base;
    e.ce1 = 1'b0;
    e.ce2 = (sz == 1) ? 1'b0 : 1'b1;
    e.a0  = (sz == 1) ? 1'b0 : addr[0];
    e.regn = (sp == 0);
    e.wr = wr;
    if (sp == 2) e.strb = wr ? 4'b0001 : 4'b0010;
    else         e.strb = wr ? 4'b0100 : 4'b1000;
    e.rdata = 16'hC000 + 16'(e.len - 1);
    e.dout = (sz == 1) ? wd : {8'h00, wd[7:0]};
    e.tag = tag;
    sb.push_back(e);
    @(negedge clk);
    cfg_mem_len  = WAIT_W'((sp == 0) ? cfg : cfg + 10);
    cfg_attr_len = WAIT_W'((sp == 1) ? cfg : cfg + 10);
    cfg_io_len   = WAIT_W'((sp == 2) ? cfg : cfg + 10);
    req_valid = 1'b1; req_space = 2'(sp); req_size = 2'(sz);
    req_write = wr; req_addr = ADDR_W'(addr); req_wdata = wd;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    while (!(rsp_done || rsp_error)) @(negedge clk);
    @(negedge clk);
  endtask

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_err++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 100000);
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    check(req_ready && !rsp_done && !rsp_error, "R11", "idle flags after reset",
          {req_ready, rsp_done, rsp_error}, 3'b100);
    check({ce1_n, ce2_n, reg_n, oe_n, we_n, iord_n, iowr_n} == 7'h7F, "R3",
          "card lines after reset", {ce1_n, ce2_n, reg_n, oe_n, we_n, iord_n, iowr_n}, 7'h7F);
    check(!card_doe, "R13", "doe after reset", card_doe, 0);

    run_access(0, 0, 0, 'h124, 16'h0, 3, "R2");        // memory byte read even, R5
    run_access(0, 0, 0, 'h125, 16'h0, 3, "R5");        // memory byte read odd
    run_access(0, 1, 1, 'h040, 16'hBEEF, 5, "R6");     // memory word write
    run_access(1, 0, 0, 'h010, 16'h0, 4, "R4");        // attribute byte read
    run_access(1, 0, 0, 'h011, 16'h0, 4, "R8");        // attribute odd refused
    run_access(1, 1, 1, 'h013, 16'h1111, 4, "R8");     // attribute odd word refused
    run_access(2, 0, 1, 'h007, 16'h5A3C, 6, "R3");     // I/O byte write odd
    run_access(2, 1, 0, 'h200, 16'h0, 2, "R3");        // I/O word read
    run_access(0, 2, 0, 'h001, 16'h0, 3, "R7");        // high-lane odd byte refused
    run_access(0, 3, 1, 'h002, 16'h0, 3, "R7");        // size 3 refused
    run_access(3, 0, 0, 'h002, 16'h0, 3, "R7");        // space 3 refused
    run_access(0, 1, 0, 'h003, 16'h0, 3, "R6");        // odd word refused
    run_access(1, 0, 1, 'h3FE, 16'h00A7, 0, "R2");     // zero length gives one cycle

    // R10: wait from strobe cycle 2 for 3 cycles, base 6 -> 8
    wdly = 1; wlen = 3; cfg_wait_en = 1'b1;
    run_access(0, 0, 0, 'h050, 16'h0, 6, "R10");
    // R9: same pattern with wait disabled -> 6
    cfg_wait_en = 1'b0;
    run_access(0, 0, 0, 'h050, 16'h0, 6, "R9");
    run_access(2, 0, 1, 'h051, 16'h0042, 6, "R9");
    // R10: short wait, base length dominates -> 10
    wdly = 2; wlen = 1; cfg_wait_en = 1'b1;
    run_access(1, 1, 0, 'h060, 16'h0, 10, "R10");
    // R10: I/O, wait from first strobe cycle, base 5 -> 6
    wdly = 0; wlen = 2;
    run_access(2, 1, 1, 'h070, 16'hCAFE, 5, "R10");
    wlen = 0; cfg_wait_en = 1'b0;

    repeat (4) @(negedge clk);
    check(sb.size() == 0, "R11", "responses outstanding", sb.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

endmodule